// File: doc/BRIEF.md
# Scanline Video Fetch Scheduler

This block decides, one memory cycle at a time, what kind of video access a character, bitmap or bitplane display controller performs on each scanned line. A line begins with a horizontal-sync pulse. Six refresh cycles follow. Then come the sprite groups, and after them the display fetches for as long as the display window is open. Every access cycle carries a fetch-kind code, a data-bus select, a bitplane or sprite index, and column-strobe enables for memory banks A and B.

The caller provides a cycle strobe. The scheduler moves forward only on strobed cycles, and its registered descriptor holds between strobes. The mode bits, the bitplane enable mask and the per-sprite flags are captured on the sync pulse and used for the whole line. Address generation, pixel shifting and DRAM timing are handled by the logic around this block.

Top module: `fetch_sched`

## Requirements
- R1: After reset the outputs are the idle descriptor: kind 0, bus 2'b00, both column strobes low, plane and sprite indices 0.
- R2: In the cycle after `hsync_i` the output is idle. The bitmap bit, bitplane bit, plane mask and sprite flags are captured at `hsync_i`, and changes to those inputs later in the line have no effect until the next sync.
- R3: The first six strobes after a sync each produce kind 5 (refresh) with bus 2'b00 and both column strobes low. No line has more than six.
- R4: After the refresh cycles, each sprite whose enable and on-line flags are both set gets one pointer access (kind 6) followed by three data accesses (kind 7). The groups come in ascending sprite order and carry the index on `spr_o`, with bus 2'b01 and only `cas_a_o` high. Skipped sprites use no strobes.
- R5: In text mode (bitplane bit 0, bitmap bit 0), displayed strobes alternate between a matrix access (kind 1, bus 2'b11, both strobes high) and a character access (kind 2, bus 2'b01, `cas_a_o` only), starting with the matrix access.
- R6: In bitmap mode (bitplane bit 0, bitmap bit 1), the follow-up to each matrix access is kind 3 (bus 2'b01, `cas_a_o` only), and kind 2 never appears.
- R7: In bitplane mode, each displayed strobe gives kind 4 for the next enabled plane in ascending order, wrapping after the highest enabled plane. Even planes use bus 2'b01 with `cas_a_o`. Odd planes use bus 2'b10 with `cas_b_o`. An all-zero mask gives idle.
- R8: A strobe outside refresh and sprite slots with `disp_i` low gives idle. When display resumes, legacy pairing starts again with a matrix access, and bitplane rotation starts again at the lowest enabled plane.
- R9: Outputs change only after a strobed or sync cycle and hold their value otherwise.
- R10: Refresh takes priority over sprites, and sprites take priority over display fetches, even while `disp_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Memory-cycle strobe |
| hsync_i | input | 1 | Line restart pulse |
| disp_i | input | 1 | Display window open |
| bmm_i | input | 1 | Bitmap mode |
| bpm_i | input | 1 | Bitplane mode |
| bp_en_i | input | N_BP | Bitplane enable mask |
| spr_en_i | input | N_SPR | Sprite enables |
| spr_act_i | input | N_SPR | Sprite displayed on this line |
| kind_o | output | 3 | Fetch kind code |
| bus_o | output | 2 | Bus select: bit0 primary, bit1 secondary |
| plane_o | output | clog2(N_BP) | Bitplane index |
| spr_o | output | clog2(N_SPR) | Sprite index |
| cas_a_o | output | 1 | Bank A column strobe enable |
| cas_b_o | output | 1 | Bank B column strobe enable |

## Verification
Each piece of internal state shows up in the very next descriptor. A wrong refresh count adds or drops a kind-5 cycle right after sync. A stale sprite mask or sub-count breaks the one-pointer-three-data pattern or puts indices out of order. A wrong matrix phase or plane rotation gives two matrix accesses in a row or a plane out of order, or the wrong bus for a plane. The checks compare every strobe against a model built from the requirements, so any such fault appears within one strobe of its cause.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    K_IDLE   = 3'd0,
    K_MATRIX = 3'd1,
    K_CHAR   = 3'd2,
    K_BITMAP = 3'd3,
    K_PLANE  = 3'd4,
    K_RFSH   = 3'd5,
    K_SPTR   = 3'd6,
    K_SDAT   = 3'd7
  } kind_e;

  localparam logic [1:0] BUS_NONE = 2'b00;
  localparam logic [1:0] BUS_PRI  = 2'b01;
  localparam logic [1:0] BUS_SEC  = 2'b10;
  localparam logic [1:0] BUS_BOTH = 2'b11;
endpackage

// File: rtl/fs_lowbit.sv
module fs_lowbit #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/fs_spr_grp.sv
module fs_spr_grp #(
  parameter int N_SPR = 8,
  localparam int SW = (N_SPR > 1) ? $clog2(N_SPR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N_SPR-1:0] en_i,
  input  logic [N_SPR-1:0] act_i,
  input  logic             step_i,
  output logic             busy_o,
  output logic             ptr_o,
  output logic [SW-1:0]    idx_o
);
  logic [N_SPR-1:0] pend_q;
  logic [1:0]       sub_q;

  fs_lowbit #(.N(N_SPR)) u_pick (
    .vec_i  (pend_q),
    .found_o(busy_o),
    .idx_o  (idx_o)
  );

  assign ptr_o = (sub_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      sub_q  <= '0;
    end else if (load_i) begin
      pend_q <= en_i & act_i;
      sub_q  <= '0;
    end else if (step_i && busy_o) begin
      if (sub_q == 2'd3) begin
        sub_q          <= '0;
        pend_q[idx_o]  <= 1'b0;
      end else begin
        sub_q <= sub_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/fs_disp_seq.sv
module fs_disp_seq
  import fs_pkg::*;
#(
  parameter int N_BP = 8,
  localparam int BW = (N_BP > 1) ? $clog2(N_BP) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            bmm_i,
  input  logic            bpm_i,
  input  logic [N_BP-1:0] mask_i,
  input  logic            step_i,
  input  logic            clr_i,
  output kind_e           kind_o,
  output logic [1:0]      bus_o,
  output logic [BW-1:0]   plane_o,
  output logic            cas_a_o,
  output logic            cas_b_o
);
  logic            bmm_q, bpm_q, phase_q;
  logic [N_BP-1:0] mask_q, left_q, avail;
  logic            found;
  logic [BW-1:0]   pick;

  // rotation restarts from the full mask once every plane was served
  assign avail = (left_q == '0) ? mask_q : left_q;

  fs_lowbit #(.N(N_BP)) u_pick (
    .vec_i  (avail),
    .found_o(found),
    .idx_o  (pick)
  );

  always_comb begin
    kind_o  = K_IDLE;
    bus_o   = BUS_NONE;
    plane_o = '0;
    cas_a_o = 1'b0;
    cas_b_o = 1'b0;
    if (bpm_q) begin
      if (found) begin
        kind_o  = K_PLANE;
        plane_o = pick;
        bus_o   = pick[0] ? BUS_SEC : BUS_PRI;
        cas_a_o = !pick[0];
        cas_b_o = pick[0];
      end
    end else if (!phase_q) begin
      kind_o  = K_MATRIX;
      bus_o   = BUS_BOTH;
      cas_a_o = 1'b1;
      cas_b_o = 1'b1;
    end else begin
      kind_o  = bmm_q ? K_BITMAP : K_CHAR;
      bus_o   = BUS_PRI;
      cas_a_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bmm_q   <= 1'b0;
      bpm_q   <= 1'b0;
      mask_q  <= '0;
      phase_q <= 1'b0;
      left_q  <= '0;
    end else if (load_i) begin
      bmm_q   <= bmm_i;
      bpm_q   <= bpm_i;
      mask_q  <= mask_i;
      phase_q <= 1'b0;
      left_q  <= '0;
    end else if (clr_i) begin
      phase_q <= 1'b0;
      left_q  <= '0;
    end else if (step_i) begin
      if (!bpm_q) phase_q <= !phase_q;
      else if (found) left_q <= avail & ~(N_BP'(1) << pick);
    end
  end
endmodule

// File: rtl/fetch_sched.sv
module fetch_sched
  import fs_pkg::*;
#(
  parameter int N_SPR  = 8,
  parameter int N_BP   = 8,
  parameter int N_RFSH = 6,
  localparam int SW = (N_SPR > 1) ? $clog2(N_SPR) : 1,
  localparam int BW = (N_BP > 1) ? $clog2(N_BP) : 1,
  localparam int RW = $clog2(N_RFSH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  input  logic             hsync_i,
  input  logic             disp_i,
  input  logic             bmm_i,
  input  logic             bpm_i,
  input  logic [N_BP-1:0]  bp_en_i,
  input  logic [N_SPR-1:0] spr_en_i,
  input  logic [N_SPR-1:0] spr_act_i,
  output logic [2:0]       kind_o,
  output logic [1:0]       bus_o,
  output logic [BW-1:0]    plane_o,
  output logic [SW-1:0]    spr_o,
  output logic             cas_a_o,
  output logic             cas_b_o
);
  logic [RW-1:0] rf_q;
  logic          in_rf, run;
  logic          spr_busy, spr_ptr;
  logic [SW-1:0] spr_idx;
  kind_e         d_kind;
  logic [1:0]    d_bus;
  logic [BW-1:0] d_plane;
  logic          d_cas_a, d_cas_b;

  kind_e         n_kind;
  logic [1:0]    n_bus;
  logic [BW-1:0] n_plane;
  logic [SW-1:0] n_spr;
  logic          n_cas_a, n_cas_b;

  assign in_rf = (rf_q != RW'(N_RFSH));
  assign run   = cyc_en_i && !hsync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rf_q <= RW'(N_RFSH);
    else if (hsync_i)           rf_q <= '0;
    else if (cyc_en_i && in_rf) rf_q <= rf_q + RW'(1);
  end

  fs_spr_grp #(.N_SPR(N_SPR)) u_spr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(hsync_i),
    .en_i  (spr_en_i),
    .act_i (spr_act_i),
    .step_i(run && !in_rf),
    .busy_o(spr_busy),
    .ptr_o (spr_ptr),
    .idx_o (spr_idx)
  );

  fs_disp_seq #(.N_BP(N_BP)) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (hsync_i),
    .bmm_i  (bmm_i),
    .bpm_i  (bpm_i),
    .mask_i (bp_en_i),
    .step_i (run && !in_rf && !spr_busy && disp_i),
    .clr_i  (run && !in_rf && !spr_busy && !disp_i),
    .kind_o (d_kind),
    .bus_o  (d_bus),
    .plane_o(d_plane),
    .cas_a_o(d_cas_a),
    .cas_b_o(d_cas_b)
  );

  // slot priority: refresh, sprite group, display, idle
  always_comb begin
    n_kind  = K_IDLE;
    n_bus   = BUS_NONE;
    n_plane = '0;
    n_spr   = '0;
    n_cas_a = 1'b0;
    n_cas_b = 1'b0;
    if (in_rf) begin
      n_kind = K_RFSH;
    end else if (spr_busy) begin
      n_kind  = spr_ptr ? K_SPTR : K_SDAT;
      n_spr   = spr_idx;
      n_bus   = BUS_PRI;
      n_cas_a = 1'b1;
    end else if (disp_i) begin
      n_kind  = d_kind;
      n_bus   = d_bus;
      n_plane = d_plane;
      n_cas_a = d_cas_a;
      n_cas_b = d_cas_b;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o  <= K_IDLE;
      bus_o   <= BUS_NONE;
      plane_o <= '0;
      spr_o   <= '0;
      cas_a_o <= 1'b0;
      cas_b_o <= 1'b0;
    end else if (hsync_i) begin
      kind_o  <= K_IDLE;
      bus_o   <= BUS_NONE;
      plane_o <= '0;
      spr_o   <= '0;
      cas_a_o <= 1'b0;
      cas_b_o <= 1'b0;
    end else if (cyc_en_i) begin
      kind_o  <= n_kind;
      bus_o   <= n_bus;
      plane_o <= n_plane;
      spr_o   <= n_spr;
      cas_a_o <= n_cas_a;
      cas_b_o <= n_cas_b;
    end
  end
endmodule

// File: rtl/fetch_sched_chk.sv
module fetch_sched_chk
  import fs_pkg::*;
#(
  parameter int N_SPR  = 8,
  parameter int N_BP   = 8,
  parameter int N_RFSH = 6,
  localparam int SW = (N_SPR > 1) ? $clog2(N_SPR) : 1,
  localparam int BW = (N_BP > 1) ? $clog2(N_BP) : 1,
  localparam int CW = $clog2(N_RFSH + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cyc_en_i,
  input logic          hsync_i,
  input logic [2:0]    kind_o,
  input logic [1:0]    bus_o,
  input logic [BW-1:0] plane_o,
  input logic [SW-1:0] spr_o,
  input logic          cas_a_o,
  input logic          cas_b_o
);
  logic [2:0]    prev_kind_q;
  logic [SW-1:0] prev_spr_q;
  logic          upd_q;
  logic [CW-1:0] rf_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_kind_q <= K_IDLE;
      prev_spr_q  <= '0;
      upd_q       <= 1'b0;
      rf_cnt_q    <= '0;
    end else begin
      upd_q <= cyc_en_i || hsync_i;
      if (cyc_en_i || hsync_i) begin
        prev_kind_q <= kind_o;
        prev_spr_q  <= spr_o;
      end
      if (hsync_i) rf_cnt_q <= '0;
      else if (upd_q && kind_o == K_RFSH && rf_cnt_q != '1) rf_cnt_q <= rf_cnt_q + CW'(1);
    end
  end

  assert_rfsh_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == K_RFSH |-> (!cas_a_o && !cas_b_o && bus_o == BUS_NONE));

  assert_rfsh_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_cnt_q <= CW'(N_RFSH));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == K_IDLE |-> (!cas_a_o && !cas_b_o && bus_o == BUS_NONE));

  assert_matrix_dual_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == K_MATRIX |-> (bus_o == BUS_BOTH && cas_a_o && cas_b_o));

  assert_follow_matrix_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == K_CHAR || kind_o == K_BITMAP) |-> prev_kind_q == K_MATRIX);

  assert_sdat_group_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == K_SDAT |-> ((prev_kind_q == K_SPTR || prev_kind_q == K_SDAT) && spr_o == prev_spr_q));

  assert_plane_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == K_PLANE |-> (bus_o == (plane_o[0] ? BUS_SEC : BUS_PRI)
                           && cas_b_o == plane_o[0] && cas_a_o == !plane_o[0]));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_en_i && !hsync_i) |=> ($stable(kind_o) && $stable(bus_o) && $stable(spr_o)
                                 && $stable(plane_o) && $stable(cas_a_o) && $stable(cas_b_o)));
endmodule

bind fetch_sched fetch_sched_chk #(.N_SPR(N_SPR), .N_BP(N_BP), .N_RFSH(N_RFSH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cyc_en_i(cyc_en_i),
  .hsync_i (hsync_i),
  .kind_o  (kind_o),
  .bus_o   (bus_o),
  .plane_o (plane_o),
  .spr_o   (spr_o),
  .cas_a_o (cas_a_o),
  .cas_b_o (cas_b_o)
);

// File: tb/tb_fetch_sched.sv
module tb_fetch_sched;
  localparam int NS = 8;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_en_i = 1'b0, hsync_i = 1'b0, disp_i = 1'b0, bmm_i = 1'b0, bpm_i = 1'b0;
  logic [NB-1:0] bp_en_i = '0;
  logic [NS-1:0] spr_en_i = '0, spr_act_i = '0;
  logic [2:0] kind_o;
  logic [1:0] bus_o;
  logic [2:0] plane_o, spr_o;
  logic cas_a_o, cas_b_o;

  always #4 clk = ~clk;

  fetch_sched dut (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_en_i(cyc_en_i), .hsync_i(hsync_i), .disp_i(disp_i),
    .bmm_i(bmm_i), .bpm_i(bpm_i), .bp_en_i(bp_en_i), .spr_en_i(spr_en_i), .spr_act_i(spr_act_i),
    .kind_o(kind_o), .bus_o(bus_o), .plane_o(plane_o), .spr_o(spr_o),
    .cas_a_o(cas_a_o), .cas_b_o(cas_b_o)
  );

  typedef struct {
    logic [2:0] k; logic [1:0] b; logic [2:0] p; logic [2:0] s; logic ca; logic cb; string tag;
  } item_t;

  item_t exp_q[$];
  item_t last;
  int checks = 0, fails = 0;
  string tag_ovr = "";

  // reference model state
  int m_rf = 6, m_sub = 0;
  logic [NS-1:0] m_spr = '0;
  logic [NB-1:0] m_left = '0, m_mask = '0;
  logic m_ph = 0, m_bmm = 0, m_bpm = 0;

  function automatic item_t idle_item(string t);
    item_t e;
    e.k = 0; e.b = 0; e.p = 0; e.s = 0; e.ca = 0; e.cb = 0; e.tag = t;
    return e;
  endfunction

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic compare(item_t e);
    checks++;
    if (kind_o !== e.k || bus_o !== e.b || plane_o !== e.p || spr_o !== e.s ||
        cas_a_o !== e.ca || cas_b_o !== e.cb) begin
      fails++;
      $display("FAIL %s: got k=%0d b=%b p=%0d s=%0d ca=%b cb=%b exp k=%0d b=%b p=%0d s=%0d ca=%b cb=%b",
               e.tag, kind_o, bus_o, plane_o, spr_o, cas_a_o, cas_b_o,
               e.k, e.b, e.p, e.s, e.ca, e.cb);
    end
  endtask

  // monitor: pops on update edges, checks hold otherwise
  initial begin
    last = idle_item("R1");
    forever begin
      logic upd;
      @(posedge clk);
      upd = rst_ni && (cyc_en_i || hsync_i);
      #2;
      if (rst_ni) begin
        if (upd) begin
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R9: got update with empty expectation queue, exp none");
          end else begin
            last = exp_q.pop_front();
          end
        end else if (last.tag != "R1") begin
          last.tag = "R9";
        end
        compare(last);
      end
    end
  end

  task automatic hs(logic bmm, logic bpm, logic [NB-1:0] mask, logic [NS-1:0] sen, logic [NS-1:0] sact);
    @(negedge clk);
    hsync_i = 1; cyc_en_i = 0; bmm_i = bmm; bpm_i = bpm; bp_en_i = mask;
    spr_en_i = sen; spr_act_i = sact;
    m_bmm = bmm; m_bpm = bpm; m_mask = mask; m_rf = 0; m_spr = sen & sact;
    m_sub = 0; m_ph = 0; m_left = '0;
    exp_q.push_back(idle_item("R2"));
  endtask

  // change captured inputs mid-line without a strobe (must be ignored: R2)
  task automatic poke(logic bmm, logic bpm, logic [NB-1:0] mask, logic [NS-1:0] sen, logic [NS-1:0] sact);
    @(negedge clk);
    hsync_i = 0; cyc_en_i = 0; bmm_i = bmm; bpm_i = bpm; bp_en_i = mask;
    spr_en_i = sen; spr_act_i = sact;
  endtask

  task automatic gap();
    @(negedge clk);
    hsync_i = 0; cyc_en_i = 0;
  endtask

  task automatic st(logic disp);
    item_t e;
    @(negedge clk);
    hsync_i = 0; cyc_en_i = 1; disp_i = disp;
    e = idle_item("R8");
    if (m_rf < 6) begin
      e.k = 5; e.tag = "R3"; m_rf++;
    end else if (m_spr != 0) begin
      int i;
      i = lowest(m_spr);
      e.s = 3'(i); e.k = (m_sub == 0) ? 3'd6 : 3'd7; e.b = 2'b01; e.ca = 1; e.tag = "R4";
      if (m_sub == 3) begin m_sub = 0; m_spr[i] = 1'b0; end
      else m_sub++;
    end else if (disp) begin
      if (m_bpm) begin
        logic [NB-1:0] avail;
        avail = (m_left == 0) ? m_mask : m_left;
        e.tag = "R7";
        if (avail != 0) begin
          int i;
          i = lowest(avail);
          e.k = 4; e.p = 3'(i); e.b = (i % 2 == 1) ? 2'b10 : 2'b01;
          e.ca = (i % 2 == 0); e.cb = (i % 2 == 1);
          m_left = avail & ~(NB'(1) << i);
        end
      end else if (!m_ph) begin
        e.k = 1; e.b = 2'b11; e.ca = 1; e.cb = 1; e.tag = "R5"; m_ph = 1;
      end else begin
        e.k = m_bmm ? 3'd3 : 3'd2; e.b = 2'b01; e.ca = 1; e.tag = m_bmm ? "R6" : "R5"; m_ph = 0;
      end
    end else begin
      m_ph = 0; m_left = '0;
    end
    if (tag_ovr != "") e.tag = tag_ovr;
    exp_q.push_back(e);
  endtask

  task automatic run(int n, logic disp);
    for (int i = 0; i < n; i++) st(disp);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) gap();                       // R1 reset state held

    // text line, sprites 0,5,7 selected (R3, R4, R5, R8)
    hs(0, 0, '0, 8'b1010_0101, 8'b1111_0001);
    run(6, 0);
    run(12, 0);
    run(2, 0);
    run(9, 1);
    gap(); gap();                           // R9 hold between strobes
    run(3, 1);
    run(1, 0);
    run(3, 1);                              // R8 restart with matrix

    // bitmap line with mid-line changes that must be ignored (R6, R2)
    hs(1, 0, '0, '0, '0);
    run(6, 0);
    run(8, 1);
    poke(0, 1, 8'hFF, 8'hFF, 8'hFF);
    tag_ovr = "R2";
    run(4, 1);
    tag_ovr = "";

    // bitplane planes 1,2,5,7 (R7, R8)
    hs(0, 1, 8'b1010_0110, '0, '0);
    run(6, 1);
    run(10, 1);
    run(1, 0);
    run(3, 1);

    // bitplane empty mask gives idle (R7)
    hs(0, 1, '0, '0, '0);
    run(6, 0);
    run(4, 1);

    // priority with display open throughout (R10)
    tag_ovr = "R10";
    hs(0, 0, '0, 8'hFF, 8'hFF);
    run(6 + 32 + 4, 1);
    // restart mid-sprite phase (R2, R3)
    hs(1, 0, '0, 8'b0000_0010, 8'b0000_0010);
    run(8, 1);
    tag_ovr = "";
    hs(0, 0, '0, '0, '0);
    run(8, 1);

    gap(); gap(); gap();
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9: got %0d pending expectations, exp 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule